// File: doc/BRIEF.md
# Power-Down and Start-Up Sequencer for a Converter Output Path

This block owns the digital reset and start-up of a multichannel converter's sample output. An active-low power-down pin clears every register at once and holds the downstream filter path in reset. When the pin is released, the release passes through a two-flop synchronizer into the system clock domain. From then on the block counts rising edges of the frame clock across a start-up window. Until the window closes, every channel of the output sample bus is held at zero. When the window closes, a data-valid flag rises and the real samples pass through.

The window length depends on the interface role. A frame-clock master needs one rising edge fewer than a slave. The block also watches the clock-select setting: any change to it restarts the window, as if the part had just left power-down. The frame clock is oversampled by the system clock. If the frame clock stops, the window count simply waits, so a stalled frame clock can never cause the window to time out.

Top module: `pwrup_init_seq`

## Requirements
- R1: While `pdn_ni` is low, `data_valid_o` is 0, `filt_rst_no` is 0 and `sample_o` is all zeros, whatever the other inputs do. All three take these values immediately when `pdn_ni` falls, without waiting for a clock edge.
- R2: After `pdn_ni` rises, `filt_rst_no` goes high on the second rising edge of `clk_i`, and not on the first.
- R3: With `master_i` = 1, `data_valid_o` stays 0 through the 515th rising edge of `frame_clk_i` after the synchronized release. It is 1 within four `clk_i` cycles after the 516th rising edge.
- R4: With `master_i` = 0, `data_valid_o` stays 0 through the 516th rising edge of `frame_clk_i`. It is 1 within four `clk_i` cycles after the 517th rising edge.
- R5: Bits [c*DW +: DW] of `sample_o` carry channel c. While `data_valid_o` is 0 they are zero. While it is 1 they equal the same bits of `sample_i`, with no register in the path.
- R6: A change of `clk_sel_i` drops `data_valid_o` to 0 within two `clk_i` cycles and restarts the window from zero. The full R3 or R4 edge count is then needed again.
- R7: While `frame_clk_i` has no rising edges, the window count holds its value. A long stall neither completes the window nor loses the edges already counted.
- R8: Once `data_valid_o` is 1, it stays 1 while `pdn_ni` is high and `clk_sel_i` is unchanged, even if `frame_clk_i` stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the frame clock |
| pdn_ni | input | 1 | Active-low power-down; asynchronous assert |
| frame_clk_i | input | 1 | Frame clock; its rising edges are counted |
| master_i | input | 1 | 1 = frame-clock master, 0 = slave |
| clk_sel_i | input | CKS_W | Clock-select setting; a change forces re-initialization |
| sample_i | input | NCH*DW | Channel samples from the filter path |
| sample_o | output | NCH*DW | Channel samples, zeroed until valid |
| filt_rst_no | output | 1 | Active-low reset for the filter path |
| data_valid_o | output | 1 | High when output samples are real data |

## Verification
The assertions assume the following about the inputs:
- `master_i` does not change while a window is in progress.
- `frame_clk_i` stays high or low for at least two `clk_i` cycles per phase, so every edge is caught by the oversampler.
- `frame_clk_i` is low or steady when power-down is released.

The stimulus keeps to all three. It changes `master_i` only while `pdn_ni` is low, drives the frame clock with four-cycle phases, and releases power-down with the frame clock low. Window lengths are checked on both sides of the boundary count, in each mode and after a clock-select restart.

// File: rtl/pwrup_init_pkg.sv
package pwrup_init_pkg;
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pdn_release_sync.sv
module pdn_release_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic pdn_ni,
    output logic run_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.chain = {s_q.chain[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge pdn_ni) begin
        if (!pdn_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign run_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/frame_edge_det.sv
module frame_edge_det (
    input  logic clk_i,
    input  logic pdn_ni,
    input  logic frame_clk_i,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.meta   = frame_clk_i;
        e_d.stable = e_q.meta;
        e_d.prev   = e_q.stable;
    end

    // chain resets high so a frame clock already high at release is not an edge
    always_ff @(posedge clk_i or negedge pdn_ni) begin
        if (!pdn_ni) e_q <= '1;
        else         e_q <= e_d;
    end

    assign rise_o = e_q.stable & ~e_q.prev;
endmodule

// File: rtl/init_window_ctr.sv
module init_window_ctr #(
    parameter int unsigned LEN_MASTER = 516,
    parameter int unsigned LEN_SLAVE  = 517,
    parameter int unsigned CKS_W      = 3
) (
    input  logic             clk_i,
    input  logic             pdn_ni,
    input  logic             run_i,
    input  logic             rise_i,
    input  logic             master_i,
    input  logic [CKS_W-1:0] cks_i,
    output logic             valid_o
);
    import pwrup_init_pkg::*;

    localparam int unsigned MAXLEN = max_u(LEN_MASTER, LEN_SLAVE);
    localparam int unsigned CW     = $clog2(MAXLEN + 1);
    localparam logic [CW-1:0] TGT_M = CW'(LEN_MASTER);
    localparam logic [CW-1:0] TGT_S = CW'(LEN_SLAVE);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [CKS_W-1:0] cks;
        logic             valid;
    } ctr_t;

    ctr_t c_d, c_q;
    logic [CW-1:0] target;
    logic          cks_chg;

    always_comb begin
        target  = (role_e'(master_i) == ROLE_MASTER) ? TGT_M : TGT_S;
        cks_chg = (cks_i != c_q.cks);
        c_d     = c_q;
        if (!run_i) begin
            c_d.cnt   = '0;
            c_d.valid = 1'b0;
            c_d.cks   = cks_i;
        end else if (cks_chg) begin
            c_d.cnt   = '0;
            c_d.valid = 1'b0;
            c_d.cks   = cks_i;
        end else if (!c_q.valid && rise_i) begin
            c_d.cnt = c_q.cnt + 1'b1;
            if (c_q.cnt + 1'b1 >= target) c_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge pdn_ni) begin
        if (!pdn_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign valid_o = c_q.valid;

    // R7
    frame_stall_hold_chk: assert property (@(posedge clk_i) disable iff (!run_i)
        (!rise_i && cks_i == c_q.cks) |=> $stable(c_q.cnt));

    // R3
    window_len_chk: assert property (@(posedge clk_i) disable iff (!run_i)
        $rose(c_q.valid) |-> (c_q.cnt == target));
endmodule

// File: rtl/pwrup_init_seq.sv
module pwrup_init_seq #(
    parameter int unsigned NCH        = 4,
    parameter int unsigned DW         = 24,
    parameter int unsigned CKS_W      = 3,
    parameter int unsigned LEN_MASTER = 516,
    parameter int unsigned LEN_SLAVE  = 517
) (
    input  logic              clk_i,
    input  logic              pdn_ni,
    input  logic              frame_clk_i,
    input  logic              master_i,
    input  logic [CKS_W-1:0]  clk_sel_i,
    input  logic [NCH*DW-1:0] sample_i,
    output logic [NCH*DW-1:0] sample_o,
    output logic              filt_rst_no,
    output logic              data_valid_o
);
    logic run, rise, valid;

    pdn_release_sync #(.STAGES(2)) sync_i (
        .clk_i (clk_i),
        .pdn_ni(pdn_ni),
        .run_o (run)
    );

    frame_edge_det edge_i (
        .clk_i      (clk_i),
        .pdn_ni     (pdn_ni),
        .frame_clk_i(frame_clk_i),
        .rise_o     (rise)
    );

    init_window_ctr #(
        .LEN_MASTER(LEN_MASTER),
        .LEN_SLAVE (LEN_SLAVE),
        .CKS_W     (CKS_W)
    ) ctr_i (
        .clk_i   (clk_i),
        .pdn_ni  (pdn_ni),
        .run_i   (run),
        .rise_i  (rise),
        .master_i(master_i),
        .cks_i   (clk_sel_i),
        .valid_o (valid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign sample_o[c*DW +: DW] = valid ? sample_i[c*DW +: DW] : '0;
    end

    assign filt_rst_no  = run;
    assign data_valid_o = valid;

    // R1
    valid_needs_filt_chk: assert property (@(posedge clk_i) disable iff (!pdn_ni)
        data_valid_o |-> filt_rst_no);

    // R6
    cks_restart_chk: assert property (@(posedge clk_i) disable iff (!pdn_ni)
        !$stable(clk_sel_i) |=> !data_valid_o);

    // R8
    valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!pdn_ni)
        (data_valid_o && $stable(clk_sel_i)) |=> data_valid_o);
endmodule

// File: tb/pwrup_init_seq_tb.sv
module pwrup_init_seq_tb_top;
    localparam int unsigned NCH = 4;
    localparam int unsigned DW  = 24;
    localparam int unsigned CKW = 3;
    localparam int unsigned LM  = 516;
    localparam int unsigned LS  = 517;
    localparam time CLK_PERIOD  = 10ns;

    logic              clk = 1'b0;
    logic              pdn_n = 1'b0;
    logic              fclk = 1'b0;
    logic              master = 1'b1;
    logic [CKW-1:0]    cks = '0;
    logic [NCH*DW-1:0] din = '0;
    logic [NCH*DW-1:0] dout;
    logic              filt_n, valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrup_init_seq #(.NCH(NCH), .DW(DW), .CKS_W(CKW), .LEN_MASTER(LM), .LEN_SLAVE(LS)) dut_i (
        .clk_i(clk), .pdn_ni(pdn_n), .frame_clk_i(fclk), .master_i(master),
        .clk_sel_i(cks), .sample_i(din), .sample_o(dout),
        .filt_rst_no(filt_n), .data_valid_o(valid)
    );

    task automatic chk(input string req, input logic [NCH*DW-1:0] act, input logic [NCH*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            fclk = 1'b1; idle(4);
            fclk = 1'b0; idle(4);
        end
    endtask

    function automatic logic [NCH*DW-1:0] pattern(input int k);
        logic [NCH*DW-1:0] p;
        for (int c = 0; c < NCH; c++) p[c*DW +: DW] = DW'((k + 1) * 24'h1F3A7 + c * 24'h10101);
        return p;
    endfunction

    task automatic release_pdn();
        @(negedge clk);
        pdn_n = 1'b1;
        idle(10);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        din = pattern(0);
        idle(5);
        // R1 reset state
        chk("R1 valid", valid, 0);
        chk("R1 filt", filt_n, 0);
        chk("R1 data", dout, 0);

        // R2 two-flop release
        @(negedge clk); pdn_n = 1'b1;
        @(negedge clk); chk("R2 first edge", filt_n, 0);
        @(negedge clk); chk("R2 second edge", filt_n, 1);
        idle(8);

        // R3 master window
        frames(LM - 1);
        chk("R3 before last edge", valid, 0);
        chk("R5 zeroed", dout, 0);
        frames(1);
        chk("R3 after last edge", valid, 1);
        for (int k = 0; k < 8; k++) begin
            din = pattern(k);
            #1;
            chk("R5 pass", dout, pattern(k));
        end

        // R8 stall after valid
        idle(60);
        chk("R8 stalled", valid, 1);
        frames(3);
        chk("R8 more frames", valid, 1);

        // R6 clock-select change
        @(negedge clk); cks = 3'd5;
        idle(2);
        chk("R6 dropped", valid, 0);
        chk("R6 zeroed", dout, 0);
        frames(LM - 1);
        chk("R6 before full window", valid, 0);
        frames(1);
        chk("R6 after full window", valid, 1);

        // R1 asynchronous assert
        #1 pdn_n = 1'b0;
        #1;
        chk("R1 async valid", valid, 0);
        chk("R1 async filt", filt_n, 0);
        chk("R1 async data", dout, 0);
        frames(4);
        chk("R1 frames ignored", valid, 0);

        // R4 slave window with R7 stall
        master = 1'b0;
        release_pdn();
        frames(100);
        idle(300);
        chk("R7 no timeout", valid, 0);
        frames(LS - 101);
        chk("R4 before last edge", valid, 0);
        chk("R7 count kept", valid, 0);
        frames(1);
        chk("R4 after last edge", valid, 1);
        chk("R7 edges preserved", valid, 1);
        din = pattern(9);
        #1;
        chk("R5 slave pass", dout, pattern(9));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule